// File: doc/BRIEF.md
# DDR Command Timing Compliance Monitor

This block sits beside a DDR SDRAM command bus and checks each command against the minimum spacings the memory needs. It sees the decoded command, its bank and the value carried by a mode-register write. It tracks every spacing rule with its own down-counter, which the command that starts the rule loads. When a command arrives before a counter it depends on has drained, the block reports the broken rule one cycle later. It does not issue commands, carry data or model the array.

All spacings are counted in clock cycles. The defaults assume 5 ns per cycle. Cycle distance is measured between the issue cycles of the two commands: a rule of N cycles accepts the second command N cycles after the first and flags it at N-1. A command that breaks the rules still updates the tracked state, because the memory will act on it.

Mode-register writes set the write burst length. Values with a reserved CAS-latency or burst-length field raise a configuration error and leave the previous burst length in force. Every violation or configuration error also sets a sticky error flag that only reset clears.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: Command codes: 0 no-op, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH, 6 LOAD MODE; code 7 is ignored like a no-op. The cycle after each command, `viol_pulse` is 1 exactly when that command broke a rule, and `viol_code` names the rule (0 none, 1 MRD, 2 RFC, 3 RP, 4 RC, 5 RRD, 6 RCD, 7 RAS, 8 WR).
- R2: Any command other than a no-op issued less than 2 cycles after LOAD MODE is an MRD violation.
- R3: Any command other than a no-op issued less than 12 cycles after AUTO REFRESH is an RFC violation.
- R4: An ACTIVE, READ, WRITE or PRECHARGE to a bank less than 4 cycles after a PRECHARGE to that bank is an RP violation.
- R5: An ACTIVE less than 2 cycles after an ACTIVE to a different bank is an RRD violation.
- R6: A READ less than 4 cycles, or a WRITE less than 2 cycles, after ACTIVE to the same bank is an RCD violation.
- R7: A PRECHARGE less than 8 cycles after ACTIVE to the same bank is a RAS violation.
- R8: An ACTIVE less than 12 cycles after ACTIVE to the same bank is an RC violation.
- R9: A PRECHARGE to a bank is a WR violation until 2 cycles after the last data cycle of a write burst to that bank. The data cycles follow the WRITE and number 1, 2 or 4 for burst-length field (mode bits 2:0) codes 001, 010 and 011, so a WRITE at cycle w allows PRECHARGE from w+D+2.
- R10: A LOAD MODE whose CAS field (mode bits 6:4) is not 010, 011 or 100, or whose burst-length field is not 001, 010 or 011, makes `cfg_err` 1 for the following cycle and leaves the previous burst length in force. The burst length after reset is 1 cycle.
- R11: When several rules are broken at once, the reported code is the first in the order MRD, RFC, RP, RC, RRD, RCD, RAS, WR.
- R12: `err_sticky` becomes 1 the cycle after `viol_pulse` or `cfg_err` is 1 and stays 1 until reset.
- R13: During and right after reset, all outputs are 0 and no counter is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command code |
| bank | input | BANK_W | Bank address of the command |
| mode_val | input | MODE_W | Mode-register value, used with LOAD MODE |
| viol_pulse | output | 1 | A rule was broken by the previous command |
| viol_code | output | 4 | Highest-priority broken rule |
| cfg_err | output | 1 | The previous LOAD MODE carried a reserved value |
| err_sticky | output | 1 | Some violation or configuration error since reset |

## Verification
The violation code and pulse for a command are due on the clock edge that ends its issue cycle, and `cfg_err` for a LOAD MODE is due on that same edge. `err_sticky` follows one edge later. The driver applies a command at a falling edge and queues the code and configuration flag expected from the rules. The monitor takes one entry off the queue just after each rising edge, so every result is compared in exactly the cycle it is due. Each rule is driven at its exact minimum spacing and one cycle early. The sticky flag is only read after idle gaps longer than its one-edge lag.

// File: rtl/ddrmon_pkg.sv
`timescale 1ns/1ps
package ddrmon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_LMR = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;

  // Listed in reporting priority order, highest first
  typedef enum logic [3:0] {
    VC_NONE = 4'd0,
    VC_MRD  = 4'd1,
    VC_RFC  = 4'd2,
    VC_RP   = 4'd3,
    VC_RC   = 4'd4,
    VC_RRD  = 4'd5,
    VC_RCD  = 4'd6,
    VC_RAS  = 4'd7,
    VC_WR   = 4'd8
  } vcode_e;

  localparam int BURST_W = 3;

  // Data cycles of one burst; 0 marks an unsupported field code
  function automatic logic [BURST_W-1:0] burst_cycles(input logic [2:0] fld);
    case (fld)
      3'b001:  burst_cycles = 3'd1;
      3'b010:  burst_cycles = 3'd2;
      3'b011:  burst_cycles = 3'd4;
      default: burst_cycles = 3'd0;
    endcase
  endfunction

  function automatic logic cas_supported(input logic [2:0] fld);
    cas_supported = (fld == 3'b010) || (fld == 3'b011) || (fld == 3'b100);
  endfunction

endpackage

// File: rtl/ddrmon_dncnt.sv
`timescale 1ns/1ps
module ddrmon_dncnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         busy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= ld_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_CNT_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (!load && busy) |=> (cnt == $past(cnt) - 1'b1)); // R2

endmodule

// File: rtl/ddrmon_mode_reg.sv
`timescale 1ns/1ps
module ddrmon_mode_reg
  import ddrmon_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lmr,
  input  logic [MODE_W-1:0]  mode_val,
  output logic [BURST_W-1:0] bl_cyc,
  output logic               cfg_err
);

  logic [BURST_W-1:0] new_cyc;
  logic               mode_ok;

  assign new_cyc = burst_cycles(mode_val[2:0]);
  assign mode_ok = (new_cyc != '0) && cas_supported(mode_val[6:4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bl_cyc  <= BURST_W'(1);
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= lmr && !mode_ok;
      if (lmr && mode_ok) bl_cyc <= new_cyc;
    end
  end

  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (bl_cyc == 3'd1) || (bl_cyc == 3'd2) || (bl_cyc == 3'd4)); // R10

  AST_BAD_MODE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $stable(bl_cyc)); // R10

endmodule

// File: rtl/ddrmon_global_timer.sv
`timescale 1ns/1ps
module ddrmon_global_timer #(
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 12,
  parameter int T_RRD  = 2,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lmr,
  input  logic              refr,
  input  logic              act,
  input  logic [BANK_W-1:0] bank,
  output logic              mrd_busy,
  output logic              rfc_busy,
  output logic              rrd_busy,
  output logic [BANK_W-1:0] last_bank
);

  localparam int MRD_W = $clog2(T_MRD + 1);
  localparam int RFC_W = $clog2(T_RFC + 1);
  localparam int RRD_W = $clog2(T_RRD + 1);

  ddrmon_dncnt #(.W(MRD_W)) u_mrd (
    .clk(clk), .rst(rst), .load(lmr), .ld_val(MRD_W'(T_MRD - 1)), .busy(mrd_busy));

  ddrmon_dncnt #(.W(RFC_W)) u_rfc (
    .clk(clk), .rst(rst), .load(refr), .ld_val(RFC_W'(T_RFC - 1)), .busy(rfc_busy));

  ddrmon_dncnt #(.W(RRD_W)) u_rrd (
    .clk(clk), .rst(rst), .load(act), .ld_val(RRD_W'(T_RRD - 1)), .busy(rrd_busy));

  always_ff @(posedge clk) begin
    if (rst)      last_bank <= '0;
    else if (act) last_bank <= bank;
  end

  AST_REF_ARMS: assert property (@(posedge clk) disable iff (rst)
    refr |=> rfc_busy); // R3

  AST_LMR_ARMS: assert property (@(posedge clk) disable iff (rst)
    lmr |=> mrd_busy); // R2

endmodule

// File: rtl/ddrmon_bank_timer.sv
`timescale 1ns/1ps
module ddrmon_bank_timer
  import ddrmon_pkg::*;
#(
  parameter int T_RP     = 4,
  parameter int T_RCD_RD = 4,
  parameter int T_RCD_WR = 2,
  parameter int T_RAS    = 8,
  parameter int T_RC     = 12,
  parameter int T_WR     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act,
  input  logic               wr,
  input  logic               pre,
  input  logic [BURST_W-1:0] bl_cyc,
  output logic               rp_busy,
  output logic               rcdr_busy,
  output logic               rcdw_busy,
  output logic               ras_busy,
  output logic               rc_busy,
  output logic               wr_busy
);

  localparam int RP_W   = $clog2(T_RP + 1);
  localparam int RCDR_W = $clog2(T_RCD_RD + 1);
  localparam int RCDW_W = $clog2(T_RCD_WR + 1);
  localparam int RAS_W  = $clog2(T_RAS + 1);
  localparam int RC_W   = $clog2(T_RC + 1);
  localparam int WR_W   = $clog2(T_WR + 1);

  logic [BURST_W-1:0] burst_left;
  logic               burst_last;
  logic               rec_busy;

  ddrmon_dncnt #(.W(RP_W)) u_rp (
    .clk(clk), .rst(rst), .load(pre), .ld_val(RP_W'(T_RP - 1)), .busy(rp_busy));

  ddrmon_dncnt #(.W(RCDR_W)) u_rcdr (
    .clk(clk), .rst(rst), .load(act), .ld_val(RCDR_W'(T_RCD_RD - 1)), .busy(rcdr_busy));

  ddrmon_dncnt #(.W(RCDW_W)) u_rcdw (
    .clk(clk), .rst(rst), .load(act), .ld_val(RCDW_W'(T_RCD_WR - 1)), .busy(rcdw_busy));

  ddrmon_dncnt #(.W(RAS_W)) u_ras (
    .clk(clk), .rst(rst), .load(act), .ld_val(RAS_W'(T_RAS - 1)), .busy(ras_busy));

  ddrmon_dncnt #(.W(RC_W)) u_rc (
    .clk(clk), .rst(rst), .load(act), .ld_val(RC_W'(T_RC - 1)), .busy(rc_busy));

  // Data cycles still to come for the latest write burst
  always_ff @(posedge clk) begin
    if (rst)                    burst_left <= '0;
    else if (wr)                burst_left <= bl_cyc;
    else if (burst_left != '0)  burst_left <= burst_left - 1'b1;
  end

  // Recovery window opens on the final data cycle, not on the command
  assign burst_last = (burst_left == BURST_W'(1)) && !wr;

  ddrmon_dncnt #(.W(WR_W)) u_wrrec (
    .clk(clk), .rst(rst), .load(burst_last), .ld_val(WR_W'(T_WR - 1)), .busy(rec_busy));

  assign wr_busy = (burst_left != '0) || rec_busy;

  AST_ACT_ARMS: assert property (@(posedge clk) disable iff (rst)
    act |=> (ras_busy && rc_busy)); // R7

  AST_WR_ARMS: assert property (@(posedge clk) disable iff (rst)
    wr |=> wr_busy); // R9

  AST_PRE_ARMS: assert property (@(posedge clk) disable iff (rst)
    pre |=> rp_busy); // R4

endmodule

// File: rtl/ddr_cmd_timing_mon.sv
`timescale 1ns/1ps
module ddr_cmd_timing_mon
  import ddrmon_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int MODE_W   = 13,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 12,
  parameter int T_RP     = 4,
  parameter int T_RRD    = 2,
  parameter int T_RCD_RD = 4,
  parameter int T_RCD_WR = 2,
  parameter int T_RAS    = 8,
  parameter int T_RC     = 12,
  parameter int T_WR     = 2,
  localparam int BANK_W  = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [MODE_W-1:0] mode_val,
  output logic              viol_pulse,
  output logic [3:0]        viol_code,
  output logic              cfg_err,
  output logic              err_sticky
);

  cmd_e c;
  logic is_act, is_rd, is_wr, is_pre, is_ref, is_lmr, is_any, is_banked;

  assign c         = cmd_e'(cmd);
  assign is_act    = (c == CMD_ACT);
  assign is_rd     = (c == CMD_RD);
  assign is_wr     = (c == CMD_WR);
  assign is_pre    = (c == CMD_PRE);
  assign is_ref    = (c == CMD_REF);
  assign is_lmr    = (c == CMD_LMR);
  assign is_banked = is_act || is_rd || is_wr || is_pre;
  assign is_any    = is_banked || is_ref || is_lmr;

  logic [BURST_W-1:0] bl_cyc;
  logic               mrd_busy, rfc_busy, rrd_busy;
  logic [BANK_W-1:0]  last_bank;
  logic [BANKS-1:0]   rp_b, rcdr_b, rcdw_b, ras_b, rc_b, wr_b;

  ddrmon_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .lmr(is_lmr), .mode_val(mode_val),
    .bl_cyc(bl_cyc), .cfg_err(cfg_err));

  ddrmon_global_timer #(
    .T_MRD(T_MRD), .T_RFC(T_RFC), .T_RRD(T_RRD), .BANK_W(BANK_W)
  ) u_glob (
    .clk(clk), .rst(rst), .lmr(is_lmr), .refr(is_ref), .act(is_act), .bank(bank),
    .mrd_busy(mrd_busy), .rfc_busy(rfc_busy), .rrd_busy(rrd_busy), .last_bank(last_bank));

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(g));
    ddrmon_bank_timer #(
      .T_RP(T_RP), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR),
      .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
    ) u_bt (
      .clk(clk), .rst(rst),
      .act(is_act && hit), .wr(is_wr && hit), .pre(is_pre && hit),
      .bl_cyc(bl_cyc),
      .rp_busy(rp_b[g]), .rcdr_busy(rcdr_b[g]), .rcdw_busy(rcdw_b[g]),
      .ras_busy(ras_b[g]), .rc_busy(rc_b[g]), .wr_busy(wr_b[g]));
  end

  vcode_e nxt;

  always_comb begin
    if (is_any && mrd_busy)                                   nxt = VC_MRD;
    else if (is_any && rfc_busy)                              nxt = VC_RFC;
    else if (is_banked && rp_b[bank])                         nxt = VC_RP;
    else if (is_act && rc_b[bank])                            nxt = VC_RC;
    else if (is_act && rrd_busy && (bank != last_bank))       nxt = VC_RRD;
    else if ((is_rd && rcdr_b[bank]) || (is_wr && rcdw_b[bank])) nxt = VC_RCD;
    else if (is_pre && ras_b[bank])                           nxt = VC_RAS;
    else if (is_pre && wr_b[bank])                            nxt = VC_WR;
    else                                                      nxt = VC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_pulse <= 1'b0;
      viol_code  <= VC_NONE;
      err_sticky <= 1'b0;
    end else begin
      viol_pulse <= (nxt != VC_NONE);
      viol_code  <= nxt;
      err_sticky <= err_sticky || viol_pulse || cfg_err;
    end
  end

  AST_VIOL_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> ($past(cmd) != 3'd0) && ($past(cmd) != 3'd7)); // R1

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    (viol_pulse || cfg_err) |=> err_sticky); // R12

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky); // R12

  AST_MRD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (is_any && mrd_busy) |=> (viol_code == 4'd1)); // R11

endmodule

// File: tb/sim_ddr_cmd_timing_mon.sv
`timescale 1ns/1ps
module sim_ddr_cmd_timing_mon;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, LMR = 3'd6, RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  bank = 2'd0;
  logic [12:0] mode_val = 13'd0;
  logic        viol_pulse, cfg_err, err_sticky;
  logic [3:0]  viol_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] code;
    logic       cfg;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  ddr_cmd_timing_mon u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .mode_val(mode_val),
    .viol_pulse(viol_pulse), .viol_code(viol_code),
    .cfg_err(cfg_err), .err_sticky(err_sticky));

  // Driver: one command per falling edge, expectation queued alongside
  task automatic put(input logic [2:0] c, input logic [1:0] b, input logic [12:0] m,
                     input logic [3:0] e, input logic ecfg, input string tag);
    exp_t it;
    @(negedge clk);
    cmd = c; bank = b; mode_val = m;
    it.code = e; it.cfg = ecfg; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(NOP, 2'd0, 13'd0, 4'd0, 1'b0, "R1 idle");
  endtask

  task automatic check_sticky(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (err_sticky !== exp) begin
      errors++;
      $display("FAIL %s err_sticky actual=%0b expected=%0b", tag, err_sticky, exp);
    end
  endtask

  // Monitor: result of the command driven before the last rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (viol_code !== it.code || viol_pulse !== (it.code != 4'd0) || cfg_err !== it.cfg) begin
          errors++;
          $display("FAIL %s code actual=%0d expected=%0d pulse=%0b cfg actual=%0b expected=%0b",
                   it.tag, viol_code, it.code, viol_pulse, cfg_err, it.cfg);
        end
      end
    end
  end

  initial begin
    #(20 * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (viol_pulse !== 1'b0 || viol_code !== 4'd0 || cfg_err !== 1'b0 || err_sticky !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset outputs actual=%0b/%0d/%0b/%0b expected=0/0/0/0",
               viol_pulse, viol_code, cfg_err, err_sticky);
    end

    // R2 legal: mode BL4 CAS3 (0x32), ACTIVE two cycles later
    put(LMR, 2'd0, 13'h032, 4'd0, 1'b0, "R2 lmr");
    idle(1);
    put(ACT, 2'd0, 13'd0, 4'd0, 1'b0, "R2 act at min spacing");
    idle(14);
    // R3 legal: ACTIVE exactly 12 cycles after refresh
    put(REF, 2'd0, 13'd0, 4'd0, 1'b0, "R3 ref");
    idle(11);
    put(ACT, 2'd1, 13'd0, 4'd0, 1'b0, "R3 act at min spacing");
    idle(14);
    check_sticky(1'b0, "R12 clean so far");

    // R2 early
    put(LMR, 2'd0, 13'h032, 4'd0, 1'b0, "R2 lmr");
    put(ACT, 2'd0, 13'd0, 4'd1, 1'b0, "R2 act one early");
    idle(14);
    check_sticky(1'b1, "R12 set after violation");
    // R3 early
    put(REF, 2'd0, 13'd0, 4'd0, 1'b0, "R3 ref");
    idle(10);
    put(ACT, 2'd0, 13'd0, 4'd2, 1'b0, "R3 act one early");
    idle(14);

    // R4/R8 legal: precharge then re-activate at minimum
    put(ACT, 2'd2, 13'd0, 4'd0, 1'b0, "R8 act");
    idle(7);
    put(PRE, 2'd2, 13'd0, 4'd0, 1'b0, "R7 pre at min spacing");
    idle(3);
    put(ACT, 2'd2, 13'd0, 4'd0, 1'b0, "R4 act at min spacing");
    idle(14);
    // R4 early, R11 RP wins over RC
    put(ACT, 2'd2, 13'd0, 4'd0, 1'b0, "R4 act");
    idle(7);
    put(PRE, 2'd2, 13'd0, 4'd0, 1'b0, "R4 pre");
    idle(2);
    put(ACT, 2'd2, 13'd0, 4'd3, 1'b0, "R4 R11 act one early");
    idle(14);
    // R8 early
    put(ACT, 2'd3, 13'd0, 4'd0, 1'b0, "R8 act");
    idle(10);
    put(ACT, 2'd3, 13'd0, 4'd4, 1'b0, "R8 same bank act one early");
    idle(14);

    // R5 early and legal
    put(ACT, 2'd0, 13'd0, 4'd0, 1'b0, "R5 act");
    put(ACT, 2'd1, 13'd0, 4'd5, 1'b0, "R5 other bank one early");
    idle(14);
    put(ACT, 2'd0, 13'd0, 4'd0, 1'b0, "R5 act");
    idle(1);
    put(ACT, 2'd1, 13'd0, 4'd0, 1'b0, "R5 other bank at min spacing");
    idle(14);

    // R6 read and write
    put(ACT, 2'd1, 13'd0, 4'd0, 1'b0, "R6 act");
    idle(2);
    put(RD, 2'd1, 13'd0, 4'd6, 1'b0, "R6 read one early");
    idle(14);
    put(ACT, 2'd1, 13'd0, 4'd0, 1'b0, "R6 act");
    idle(3);
    put(RD, 2'd1, 13'd0, 4'd0, 1'b0, "R6 read at min spacing");
    idle(14);
    put(ACT, 2'd0, 13'd0, 4'd0, 1'b0, "R6 act");
    put(WR, 2'd0, 13'd0, 4'd6, 1'b0, "R6 write one early");
    idle(14);
    put(ACT, 2'd0, 13'd0, 4'd0, 1'b0, "R6 act");
    idle(1);
    put(WR, 2'd0, 13'd0, 4'd0, 1'b0, "R6 write at min spacing");
    idle(14);

    // R7 early
    put(ACT, 2'd2, 13'd0, 4'd0, 1'b0, "R7 act");
    idle(6);
    put(PRE, 2'd2, 13'd0, 4'd7, 1'b0, "R7 pre one early");
    idle(14);

    // R9 with BL4 (2 data cycles): write at +5, precharge legal at +9
    put(ACT, 2'd3, 13'd0, 4'd0, 1'b0, "R9 act");
    idle(4);
    put(WR, 2'd3, 13'd0, 4'd0, 1'b0, "R9 write");
    idle(2);
    put(PRE, 2'd3, 13'd0, 4'd8, 1'b0, "R9 pre one early bl4");
    idle(14);
    put(ACT, 2'd3, 13'd0, 4'd0, 1'b0, "R9 act");
    idle(4);
    put(WR, 2'd3, 13'd0, 4'd0, 1'b0, "R9 write");
    idle(3);
    put(PRE, 2'd3, 13'd0, 4'd0, 1'b0, "R9 pre at min spacing bl4");
    idle(14);

    // R9 with BL8 (0x23: CAS2, 4 data cycles)
    put(LMR, 2'd0, 13'h023, 4'd0, 1'b0, "R10 lmr bl8");
    idle(1);
    put(ACT, 2'd0, 13'd0, 4'd0, 1'b0, "R9 act");
    idle(2);
    put(WR, 2'd0, 13'd0, 4'd0, 1'b0, "R9 write");
    idle(4);
    put(PRE, 2'd0, 13'd0, 4'd8, 1'b0, "R9 pre one early bl8");
    idle(14);

    // R10 reserved CAS, then unsupported burst length; BL8 must persist
    put(LMR, 2'd0, 13'h052, 4'd0, 1'b1, "R10 reserved cas");
    idle(2);
    put(LMR, 2'd0, 13'h034, 4'd0, 1'b1, "R10 unsupported bl");
    idle(2);
    put(ACT, 2'd1, 13'd0, 4'd0, 1'b0, "R10 act");
    idle(2);
    put(WR, 2'd1, 13'd0, 4'd0, 1'b0, "R10 write");
    idle(4);
    put(PRE, 2'd1, 13'd0, 4'd8, 1'b0, "R10 bl8 kept after bad mode");
    idle(14);

    // R11 MRD over RFC
    put(REF, 2'd0, 13'd0, 4'd0, 1'b0, "R11 ref");
    put(LMR, 2'd0, 13'h023, 4'd2, 1'b0, "R11 lmr under rfc");
    put(ACT, 2'd0, 13'd0, 4'd1, 1'b0, "R11 mrd before rfc");
    idle(14);

    // R1 reserved code ignored
    put(ACT, 2'd1, 13'd0, 4'd0, 1'b0, "R1 act");
    put(RSV, 2'd1, 13'd0, 4'd0, 1'b0, "R1 code 7 ignored");
    idle(3);
    check_sticky(1'b1, "R12 still set");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1'b1;
    $finish;
  end

endmodule